// File: doc/BRIEF.md
# Committed Program-Counter Tracker

This block holds the architectural program-counter state at the retirement end of an out-of-order core. The core has branch delay slots and splits long instructions into micro-operations. Five values are kept: the current address, the address after it, and the address two steps ahead (the slot that follows a delay slot). Alongside these sit two micro-op indices, one for the current micro-op and one for the micro-op that comes next. Each time the oldest in-flight op retires, the block takes the successor fields that op recorded and moves the whole set forward by one step.

The block also builds the restart request for the fetch unit. A full flush restarts fetch from the tracker's own state. A wrong branch guess reported by the execute stage passes execute's corrected addresses through, together with the address of the branch that was guessed wrong. The branch kind of request also tells fetch to discard the op in the delay slot, because that op ran with a wrong successor address. Each of the five values can be read at all times and written from outside.

Top module: `pctrk_commit_pc`

## Requirements
- R1: While `rst_n` is low, all five architectural values are zero and `redir_valid` is 0.
- R2: After a clock edge with `cmt_valid` high, `pc_q` equals the retiring op's `cmt_npc`, `npc_q` equals its `cmt_nnpc`, and `nnpc_q` equals `cmt_nnpc + INST_BYTES`, modulo 2^AW.
- R3: After a clock edge with `cmt_valid` high, `upc_q` equals the retiring op's `cmt_nupc`, and `nupc_q` equals `cmt_nupc + 1`, wrapping modulo 2^UW (255 becomes 0 for UW = 8).
- R4: Each write enable (`wr_pc_en`, `wr_upc_en`, `wr_npc_en`, `wr_nnpc_en`, `wr_nupc_en`) loads its own value at the edge. A value whose enable is low, in a cycle with no retirement, keeps its content.
- R5: When `cmt_valid` and any write enable are high in the same cycle, the retirement update wins and the write is lost.
- R6: A `flush` sampled at an edge gives, for the following cycle, `redir_valid` = 1, `redir_branch` = 0, `redir_bad_pc` = 0, and `redir_pc`, `redir_npc`, `redir_upc` equal to `pc_q`, `npc_q`, `nupc_q` as they were in the flush cycle (before any retirement in that same cycle).
- R7: A `mispred` sampled at an edge without `flush` gives, for the following cycle, `redir_valid` = 1, `redir_branch` = 1 (the delay-slot op is discarded too), and `redir_pc`, `redir_npc`, `redir_upc`, `redir_bad_pc` equal to `ex_npc`, `ex_nnpc`, `ex_nupc`, `ex_bad_pc`.
- R8: When `flush` and `mispred` are both high, the flush request is the one sent (R6 values).
- R9: `redir_valid` is high only in a cycle that directly follows a request. After a cycle with neither request it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmt_valid | input | 1 | Oldest op retires this cycle |
| cmt_npc | input | AW | Successor address recorded by the retiring op |
| cmt_nnpc | input | AW | Two-ahead address recorded by the retiring op |
| cmt_nupc | input | UW | Successor micro-op index recorded by the retiring op |
| flush | input | 1 | Full flush request |
| mispred | input | 1 | Wrong branch guess reported by execute |
| ex_bad_pc | input | AW | Address of the wrongly guessed branch |
| ex_npc | input | AW | Corrected restart address from execute |
| ex_nnpc | input | AW | Corrected two-ahead address from execute |
| ex_nupc | input | UW | Corrected micro-op index from execute |
| wr_pc_en | input | 1 | Write current address |
| wr_pc_val | input | AW | Value for current address |
| wr_upc_en | input | 1 | Write current micro-op index |
| wr_upc_val | input | UW | Value for current micro-op index |
| wr_npc_en | input | 1 | Write successor address |
| wr_npc_val | input | AW | Value for successor address |
| wr_nnpc_en | input | 1 | Write two-ahead address |
| wr_nnpc_val | input | AW | Value for two-ahead address |
| wr_nupc_en | input | 1 | Write next micro-op index |
| wr_nupc_val | input | UW | Value for next micro-op index |
| pc_q | output | AW | Current architectural address |
| upc_q | output | UW | Current micro-op index |
| npc_q | output | AW | Successor address |
| nnpc_q | output | AW | Two-ahead address |
| nupc_q | output | UW | Next micro-op index |
| redir_valid | output | 1 | Restart request valid, one cycle |
| redir_branch | output | 1 | 1: wrong-branch kind (delay slot discarded), 0: full flush |
| redir_pc | output | AW | Restart address |
| redir_npc | output | AW | Restart successor address |
| redir_upc | output | UW | Restart micro-op index |
| redir_bad_pc | output | AW | Wrongly guessed branch address (0 on flush) |

## Verification
Every result of the block comes one edge after its cause. A retirement or write shows on the architectural outputs in the cycle after the edge that samples it. A flush or wrong-branch input raises the restart request for exactly the cycle after its edge. The bench drives inputs on the falling edge and updates a behavioural model at the rising edge that samples them. It then compares every output with that model at the next falling edge, so each result is checked in the one cycle in which it is due, and a pulse that lingers is caught as well.

// File: rtl/pctrk_pkg.sv
package pctrk_pkg;

    // Restart request emitter states
    typedef enum logic [1:0] {
        RD_IDLE   = 2'd0,
        RD_FULL   = 2'd1,
        RD_BRANCH = 2'd2
    } rd_state_e;

endpackage

// File: rtl/pctrk_field.sv
module pctrk_field #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd_en,
    input  logic [W-1:0] upd_val,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    output logic [W-1:0] q
);

    // Retirement update has priority over an external write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (upd_en)
            q <= upd_val;
        else if (wr_en)
            q <= wr_val;
    end

endmodule

// File: rtl/pctrk_arch_state.sv
module pctrk_arch_state #(
    parameter int AW         = 32,
    parameter int UW         = 8,
    parameter int INST_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmt_valid,
    input  logic [AW-1:0] cmt_npc,
    input  logic [AW-1:0] cmt_nnpc,
    input  logic [UW-1:0] cmt_nupc,
    input  logic [2:0]    wa_en,
    input  logic [AW-1:0] wa_val [3],
    input  logic [1:0]    wu_en,
    input  logic [UW-1:0] wu_val [2],
    output logic [AW-1:0] a_q [3],
    output logic [UW-1:0] u_q [2]
);

    localparam logic [AW-1:0] STEP   = AW'(INST_BYTES);
    localparam logic [UW-1:0] USTEP  = UW'(1);
    localparam int            NADDR  = 3;
    localparam int            NUOP   = 2;

    // index 0: current, 1: successor, 2: two-ahead
    logic [AW-1:0] a_upd [NADDR];
    // index 0: current micro-op, 1: next micro-op
    logic [UW-1:0] u_upd [NUOP];

    // Capture the retiring op's successor fields, then step forward once
    always_comb begin
        a_upd[0] = cmt_npc;
        a_upd[1] = cmt_nnpc;
        a_upd[2] = cmt_nnpc + STEP;
        u_upd[0] = cmt_nupc;
        u_upd[1] = cmt_nupc + USTEP;
    end

    for (genvar i = 0; i < NADDR; i++) begin : g_addr
        pctrk_field #(.W(AW)) u_fld (
            .clk     (clk),
            .rst_n   (rst_n),
            .upd_en  (cmt_valid),
            .upd_val (a_upd[i]),
            .wr_en   (wa_en[i]),
            .wr_val  (wa_val[i]),
            .q       (a_q[i])
        );
    end

    for (genvar j = 0; j < NUOP; j++) begin : g_uop
        pctrk_field #(.W(UW)) u_fld (
            .clk     (clk),
            .rst_n   (rst_n),
            .upd_en  (cmt_valid),
            .upd_val (u_upd[j]),
            .wr_en   (wu_en[j]),
            .wr_val  (wu_val[j]),
            .q       (u_q[j])
        );
    end

endmodule

// File: rtl/pctrk_redirect.sv
module pctrk_redirect
    import pctrk_pkg::*;
#(
    parameter int AW = 32,
    parameter int UW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          mispred,
    input  logic [AW-1:0] st_pc,
    input  logic [AW-1:0] st_npc,
    input  logic [UW-1:0] st_nupc,
    input  logic [AW-1:0] ex_bad_pc,
    input  logic [AW-1:0] ex_npc,
    input  logic [AW-1:0] ex_nnpc,
    input  logic [UW-1:0] ex_nupc,
    output logic          redir_valid,
    output logic          redir_branch,
    output logic [AW-1:0] redir_pc,
    output logic [AW-1:0] redir_npc,
    output logic [UW-1:0] redir_upc,
    output logic [AW-1:0] redir_bad_pc
);

    rd_state_e     state, state_nx;
    logic [AW-1:0] pl_pc, pl_npc, pl_bad;
    logic [UW-1:0] pl_upc;

    // Transitions: any state -> RD_FULL on flush,
    // -> RD_BRANCH on mispred without flush, otherwise -> RD_IDLE
    always_comb begin
        if (flush)
            state_nx = RD_FULL;
        else if (mispred)
            state_nx = RD_BRANCH;
        else
            state_nx = RD_IDLE;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= RD_IDLE;
        else
            state <= state_nx;
    end

    // Payload captured together with the state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pl_pc  <= '0;
            pl_npc <= '0;
            pl_upc <= '0;
            pl_bad <= '0;
        end else if (flush) begin
            pl_pc  <= st_pc;
            pl_npc <= st_npc;
            pl_upc <= st_nupc;
            pl_bad <= '0;
        end else if (mispred) begin
            pl_pc  <= ex_npc;
            pl_npc <= ex_nnpc;
            pl_upc <= ex_nupc;
            pl_bad <= ex_bad_pc;
        end
    end

    // Outputs
    always_comb begin
        redir_pc     = pl_pc;
        redir_npc    = pl_npc;
        redir_upc    = pl_upc;
        redir_bad_pc = pl_bad;
        unique case (state)
            RD_IDLE: begin
                redir_valid  = 1'b0;
                redir_branch = 1'b0;
            end
            RD_FULL: begin
                redir_valid  = 1'b1;
                redir_branch = 1'b0;
            end
            RD_BRANCH: begin
                redir_valid  = 1'b1;
                redir_branch = 1'b1;
            end
            default: begin
                redir_valid  = 1'b0;
                redir_branch = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pctrk_commit_pc.sv
module pctrk_commit_pc #(
    parameter int AW         = 32,
    parameter int UW         = 8,
    parameter int INST_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmt_valid,
    input  logic [AW-1:0] cmt_npc,
    input  logic [AW-1:0] cmt_nnpc,
    input  logic [UW-1:0] cmt_nupc,
    input  logic          flush,
    input  logic          mispred,
    input  logic [AW-1:0] ex_bad_pc,
    input  logic [AW-1:0] ex_npc,
    input  logic [AW-1:0] ex_nnpc,
    input  logic [UW-1:0] ex_nupc,
    input  logic          wr_pc_en,
    input  logic [AW-1:0] wr_pc_val,
    input  logic          wr_upc_en,
    input  logic [UW-1:0] wr_upc_val,
    input  logic          wr_npc_en,
    input  logic [AW-1:0] wr_npc_val,
    input  logic          wr_nnpc_en,
    input  logic [AW-1:0] wr_nnpc_val,
    input  logic          wr_nupc_en,
    input  logic [UW-1:0] wr_nupc_val,
    output logic [AW-1:0] pc_q,
    output logic [UW-1:0] upc_q,
    output logic [AW-1:0] npc_q,
    output logic [AW-1:0] nnpc_q,
    output logic [UW-1:0] nupc_q,
    output logic          redir_valid,
    output logic          redir_branch,
    output logic [AW-1:0] redir_pc,
    output logic [AW-1:0] redir_npc,
    output logic [UW-1:0] redir_upc,
    output logic [AW-1:0] redir_bad_pc
);

    logic [2:0]    wa_en;
    logic [AW-1:0] wa_val [3];
    logic [1:0]    wu_en;
    logic [UW-1:0] wu_val [2];
    logic [AW-1:0] a_q [3];
    logic [UW-1:0] u_q [2];

    always_comb begin
        wa_en     = {wr_nnpc_en, wr_npc_en, wr_pc_en};
        wa_val[0] = wr_pc_val;
        wa_val[1] = wr_npc_val;
        wa_val[2] = wr_nnpc_val;
        wu_en     = {wr_nupc_en, wr_upc_en};
        wu_val[0] = wr_upc_val;
        wu_val[1] = wr_nupc_val;
    end

    pctrk_arch_state #(
        .AW(AW), .UW(UW), .INST_BYTES(INST_BYTES)
    ) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmt_valid (cmt_valid),
        .cmt_npc   (cmt_npc),
        .cmt_nnpc  (cmt_nnpc),
        .cmt_nupc  (cmt_nupc),
        .wa_en     (wa_en),
        .wa_val    (wa_val),
        .wu_en     (wu_en),
        .wu_val    (wu_val),
        .a_q       (a_q),
        .u_q       (u_q)
    );

    assign pc_q   = a_q[0];
    assign npc_q  = a_q[1];
    assign nnpc_q = a_q[2];
    assign upc_q  = u_q[0];
    assign nupc_q = u_q[1];

    pctrk_redirect #(.AW(AW), .UW(UW)) u_redir (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush        (flush),
        .mispred      (mispred),
        .st_pc        (a_q[0]),
        .st_npc       (a_q[1]),
        .st_nupc      (u_q[1]),
        .ex_bad_pc    (ex_bad_pc),
        .ex_npc       (ex_npc),
        .ex_nnpc      (ex_nnpc),
        .ex_nupc      (ex_nupc),
        .redir_valid  (redir_valid),
        .redir_branch (redir_branch),
        .redir_pc     (redir_pc),
        .redir_npc    (redir_npc),
        .redir_upc    (redir_upc),
        .redir_bad_pc (redir_bad_pc)
    );

endmodule

// File: rtl/pctrk_checker.sv
module pctrk_checker #(
    parameter int AW         = 32,
    parameter int UW         = 8,
    parameter int INST_BYTES = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmt_valid,
    input logic [AW-1:0] cmt_npc,
    input logic [AW-1:0] cmt_nnpc,
    input logic [UW-1:0] cmt_nupc,
    input logic          flush,
    input logic          mispred,
    input logic [AW-1:0] ex_npc,
    input logic          wr_pc_en,
    input logic [AW-1:0] pc_q,
    input logic [UW-1:0] upc_q,
    input logic [AW-1:0] npc_q,
    input logic [AW-1:0] nnpc_q,
    input logic [UW-1:0] nupc_q,
    input logic          redir_valid,
    input logic          redir_branch,
    input logic [AW-1:0] redir_pc
);

    localparam logic [AW-1:0] STEP = AW'(INST_BYTES);
    localparam logic [UW-1:0] ONE  = UW'(1);

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (pc_q == '0 && upc_q == '0 && npc_q == '0 &&
                    nnpc_q == '0 && nupc_q == '0 && !redir_valid));

    p_commit_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_valid |=> (pc_q == $past(cmt_npc) && npc_q == $past(cmt_nnpc) &&
                       nnpc_q == $past(cmt_nnpc) + STEP));

    p_commit_uop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_valid |=> (upc_q == $past(cmt_nupc) && nupc_q == $past(cmt_nupc) + ONE));

    p_hold_pc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmt_valid && !wr_pc_en) |=> $stable(pc_q));

    p_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (redir_valid && !redir_branch && redir_pc == $past(pc_q)));

    p_branch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mispred && !flush) |=> (redir_valid && redir_branch && redir_pc == $past(ex_npc)));

    p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && !mispred) |=> !redir_valid);

endmodule

bind pctrk_commit_pc pctrk_checker #(
    .AW(AW), .UW(UW), .INST_BYTES(INST_BYTES)
) u_chk (.*);

// File: tb/sim_pctrk_commit_pc.sv
`timescale 1ns/1ps
module sim_pctrk_commit_pc;

    localparam int AW = 32;
    localparam int UW = 8;
    localparam int IB = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cmt_valid;
    logic [AW-1:0] cmt_npc, cmt_nnpc;
    logic [UW-1:0] cmt_nupc;
    logic          flush, mispred;
    logic [AW-1:0] ex_bad_pc, ex_npc, ex_nnpc;
    logic [UW-1:0] ex_nupc;
    logic          wr_pc_en, wr_upc_en, wr_npc_en, wr_nnpc_en, wr_nupc_en;
    logic [AW-1:0] wr_pc_val, wr_npc_val, wr_nnpc_val;
    logic [UW-1:0] wr_upc_val, wr_nupc_val;
    logic [AW-1:0] pc_q, npc_q, nnpc_q, redir_pc, redir_npc, redir_bad_pc;
    logic [UW-1:0] upc_q, nupc_q, redir_upc;
    logic          redir_valid, redir_branch;

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    longint m_pc, m_upc, m_npc, m_nnpc, m_nupc;
    longint m_rpc, m_rnpc, m_rupc, m_rbad;
    bit     m_rv, m_rb;

    always #4 clk = ~clk;

    pctrk_commit_pc #(.AW(AW), .UW(UW), .INST_BYTES(IB)) u0 (.*);

    task automatic chk(input string tag, input string nm, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, nm, act, exp);
        end
    endtask

    task automatic clr_in();
        cmt_valid = 0; cmt_npc = '0; cmt_nnpc = '0; cmt_nupc = '0;
        flush = 0; mispred = 0; ex_bad_pc = '0; ex_npc = '0; ex_nnpc = '0; ex_nupc = '0;
        wr_pc_en = 0; wr_upc_en = 0; wr_npc_en = 0; wr_nnpc_en = 0; wr_nupc_en = 0;
        wr_pc_val = '0; wr_npc_val = '0; wr_nnpc_val = '0; wr_upc_val = '0; wr_nupc_val = '0;
    endtask

    // one clock: model follows the requirements, outputs compared on the falling edge
    task automatic cyc(input string tag);
        longint amask, umask;
        amask = (64'd1 << AW) - 1;
        umask = (64'd1 << UW) - 1;
        @(posedge clk);
        if (!rst_n) begin
            m_pc = 0; m_upc = 0; m_npc = 0; m_nnpc = 0; m_nupc = 0;
            m_rv = 0; m_rb = 0; m_rpc = 0; m_rnpc = 0; m_rupc = 0; m_rbad = 0;
        end else begin
            if (flush) begin                       // R6, R8
                m_rv = 1; m_rb = 0; m_rpc = m_pc; m_rnpc = m_npc; m_rupc = m_nupc; m_rbad = 0;
            end else if (mispred) begin            // R7
                m_rv = 1; m_rb = 1; m_rpc = ex_npc; m_rnpc = ex_nnpc; m_rupc = ex_nupc; m_rbad = ex_bad_pc;
            end else begin
                m_rv = 0; m_rb = 0;                // R9
            end
            if (cmt_valid) begin                   // R2, R3, R5
                m_pc = cmt_npc; m_npc = cmt_nnpc; m_nnpc = (cmt_nnpc + IB) & amask;
                m_upc = cmt_nupc; m_nupc = (cmt_nupc + 1) & umask;
            end else begin                         // R4
                if (wr_pc_en)   m_pc   = wr_pc_val;
                if (wr_upc_en)  m_upc  = wr_upc_val;
                if (wr_npc_en)  m_npc  = wr_npc_val;
                if (wr_nnpc_en) m_nnpc = wr_nnpc_val;
                if (wr_nupc_en) m_nupc = wr_nupc_val;
            end
        end
        @(negedge clk);
        chk(tag, "pc_q", pc_q, m_pc);
        chk(tag, "upc_q", upc_q, m_upc);
        chk(tag, "npc_q", npc_q, m_npc);
        chk(tag, "nnpc_q", nnpc_q, m_nnpc);
        chk(tag, "nupc_q", nupc_q, m_nupc);
        chk(tag, "redir_valid", redir_valid, m_rv);
        if (m_rv) begin
            chk(tag, "redir_branch", redir_branch, m_rb);
            chk(tag, "redir_pc", redir_pc, m_rpc);
            chk(tag, "redir_npc", redir_npc, m_rnpc);
            chk(tag, "redir_upc", redir_upc, m_rupc);
            chk(tag, "redir_bad_pc", redir_bad_pc, m_rbad);
        end
        clr_in();
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        clr_in();
        rst_n = 0;
        cyc("R1 reset");
        cyc("R1 reset hold");
        @(negedge clk); rst_n = 1;
        cyc("R1 idle after reset");

        // R2/R3: plain retirements with distinct fields
        cmt_valid = 1; cmt_npc = 32'h1004; cmt_nnpc = 32'h1008; cmt_nupc = 8'h00;
        cyc("R2 R3 commit a");
        cmt_valid = 1; cmt_npc = 32'h1008; cmt_nnpc = 32'h2000; cmt_nupc = 8'h03;
        cyc("R2 R3 commit delay slot target");
        // R3: micro-op index wrap, R2: address wrap
        cmt_valid = 1; cmt_npc = 32'hFFFF_FFF8; cmt_nnpc = 32'hFFFF_FFFC; cmt_nupc = 8'hFF;
        cyc("R2 R3 wrap");

        // R4: each write alone, others must hold
        wr_pc_en = 1;   wr_pc_val = 32'hA000_0000;  cyc("R4 write pc");
        wr_upc_en = 1;  wr_upc_val = 8'h11;         cyc("R4 write upc");
        wr_npc_en = 1;  wr_npc_val = 32'hA000_0004; cyc("R4 write npc");
        wr_nnpc_en = 1; wr_nnpc_val = 32'hA000_0008; cyc("R4 write nnpc");
        wr_nupc_en = 1; wr_nupc_val = 8'h22;        cyc("R4 write nupc");
        cyc("R4 idle hold");

        // R5: retirement beats writes
        cmt_valid = 1; cmt_npc = 32'h3000; cmt_nnpc = 32'h3004; cmt_nupc = 8'h05;
        wr_pc_en = 1; wr_pc_val = 32'hDEAD_0000; wr_nupc_en = 1; wr_nupc_val = 8'h77;
        wr_npc_en = 1; wr_npc_val = 32'hBEEF_0000;
        cyc("R5 commit wins");

        // R6: flush from own state
        flush = 1; cyc("R6 flush");
        cyc("R9 pulse ends");
        // R6 with same-cycle retirement: request uses pre-retirement state
        flush = 1; cmt_valid = 1; cmt_npc = 32'h4000; cmt_nnpc = 32'h4004; cmt_nupc = 8'h09;
        cyc("R6 flush with commit");

        // R7: wrong branch, delay slot dropped
        mispred = 1; ex_bad_pc = 32'h5550; ex_npc = 32'h6000; ex_nnpc = 32'h6004; ex_nupc = 8'h00;
        cyc("R7 mispred");
        // back-to-back request keeps valid high
        mispred = 1; ex_bad_pc = 32'h6000; ex_npc = 32'h7000; ex_nnpc = 32'h7010; ex_nupc = 8'h02;
        cyc("R7 mispred back to back");
        cyc("R9 idle");

        // R8: both requests
        flush = 1; mispred = 1; ex_bad_pc = 32'h1234; ex_npc = 32'h9990; ex_nnpc = 32'h9994; ex_nupc = 8'h44;
        cyc("R8 flush priority");
        cyc("R9 idle after both");

        // mixed traffic
        for (int i = 0; i < 200; i++) begin
            cmt_valid = ($urandom % 2) == 0;
            cmt_npc = $urandom; cmt_nnpc = $urandom; cmt_nupc = UW'($urandom);
            flush = ($urandom % 7) == 0;
            mispred = ($urandom % 5) == 0;
            ex_bad_pc = $urandom; ex_npc = $urandom; ex_nnpc = $urandom; ex_nupc = UW'($urandom);
            wr_pc_en = ($urandom % 4) == 0;   wr_pc_val = $urandom;
            wr_upc_en = ($urandom % 4) == 0;  wr_upc_val = UW'($urandom);
            wr_npc_en = ($urandom % 4) == 0;  wr_npc_val = $urandom;
            wr_nnpc_en = ($urandom % 4) == 0; wr_nnpc_val = $urandom;
            wr_nupc_en = ($urandom % 4) == 0; wr_nupc_val = UW'($urandom);
            cyc("R2 R3 R4 R5 R6 R7 R8 R9 mixed");
        end

        // R1 again mid-run
        @(negedge clk); rst_n = 0;
        cyc("R1 second reset");
        @(negedge clk); rst_n = 1;
        cyc("R1 after second reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule